// File: doc/BRIEF.md
# Single-Word SPI Master with Register Bank

This block is a SPI master that moves one word per software request. A small register bank sits on a simple write-strobe and combinational-read bus. Software sets the clock mode, the bit order for each direction and the word length (8 or 16 bits) in a configuration register. It picks and asserts a chip select through a control register, then writes a word to the transmit register. The block shifts the word out on MOSI and collects MISO into a receive register. When the word is done, it raises a level completion flag that software clears with a write.

The SCK rate comes from outside: a separate prescaler supplies a one-cycle `sckTick` pulse for every SCK half period. A timing register sets how many system-clock cycles after the sampling SCK transition MISO is captured. This gives margin against slow slave output paths. Chip select is under software control only. It is not tied to the transfer, so several words can share one select window.

Top module: `spiMasterCtl`

## Requirements
- R1: Registers decode at byte offsets control 0x00, configuration 0x04, transmit 0x08, receive 0x0C, completion cause 0x10 and timing 0x18. After reset, control, configuration and cause read 0, and timing reads 0x40 (delay code 1 in bits [7:6]). Written fields read back unchanged.
- R2: Control bit 0 enables the chip select and control bits [4:2] choose one of 8 outputs. `spiCsN[sel]` is low only while bit 0 is 1, and every other select output stays high.
- R3: SCK rests at the CPOL level (configuration bit 11) whenever no transfer runs. During a transfer it changes level only at clock edges where `sckTick` is high.
- R4: Configuration bit 12 is CPHA. With 0, the first data bit is on MOSI before the first leading edge, and both sides sample on leading edges. With 1, MOSI changes on leading edges and sampling is on trailing edges.
- R5: Configuration bit 5 set selects 16-bit words with 16 SCK pulses. Clear selects 8-bit words with 8 pulses, and the receive register then reads zero in bits [15:8].
- R6: Configuration bit 13 set sends the transmit word LSB first, otherwise MSB first. Bit 14 set places the first received bit in the LSB, otherwise in the word's MSB.
- R7: A write to the transmit register while idle starts one word. Control bit 8 reads 1 while a word is in progress. A transmit write during a transfer is ignored.
- R8: Cause bit 0 becomes 1 when a word completes and the received word is then readable at 0x0C. The flag holds until software writes the cause register, which clears it.
- R9: Timing bits [7:6] hold a delay d. MISO is captured at the clock edge d cycles after the edge on which SCK makes its sampling transition (d = 0 means that same edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| sckTick | input | 1 | One-cycle pulse per SCK half period from the prescaler |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | 8 | Active-low chip selects |

## Verification
A wrong shift or edge counter shows up on the very word it corrupts. The MOSI bit sequence seen by the slave model, the number of SCK transitions or the receive register then differs, and the completion flag is checked a few cycles after the final edge. A wrong capture delay is only visible when MISO changes soon after the sampling edge. The bench therefore runs a slave that inverts its output one cycle after each sampling edge, which turns a one-cycle timing error into a fully inverted receive word. Select decoding and idle-level errors appear at once on `spiCsN` and `spiSck`, without any transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] regAddr_t;

  localparam regAddr_t OFF_CTRL  = 5'h00;
  localparam regAddr_t OFF_CFG   = 5'h04;
  localparam regAddr_t OFF_TX    = 5'h08;
  localparam regAddr_t OFF_RX    = 5'h0C;
  localparam regAddr_t OFF_CAUSE = 5'h10;
  localparam regAddr_t OFF_TIME  = 5'h18;

  // field positions
  localparam int CTRL_CS_EN  = 0;
  localparam int CTRL_SEL_LO = 2;
  localparam int CTRL_BUSY   = 8;
  localparam int CFG_WIDE    = 5;
  localparam int CFG_CPOL    = 11;
  localparam int CFG_CPHA    = 12;
  localparam int CFG_TXLSB   = 13;
  localparam int CFG_RXLSB   = 14;
  localparam int TIM_DLY_LO  = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_DRAIN} xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shiftTx;
    logic captureRx;
    logic latchRx;
  } dpStrobe_t;
endpackage

// File: rtl/spim_datapath.sv
module spim_datapath import spim_pkg::*; #(
  parameter int WORD_MAX = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           dpStb,
  input  logic [WORD_MAX-1:0] txWord,
  input  logic                wide,
  input  logic                txLsb,
  input  logic                rxLsb,
  input  logic                miso,
  output logic                mosi,
  output logic [WORD_MAX-1:0] rxWord
);
  localparam int NARROW = WORD_MAX / 2;

  logic [WORD_MAX-1:0] txShift;
  logic [WORD_MAX-1:0] rxShift;
  logic [WORD_MAX-1:0] rxNext;
  logic [WORD_MAX-1:0] rxHold;

  // next receive value for the chosen order and width
  always_comb begin
    rxNext = '0;
    if (!rxLsb) begin
      rxNext = {rxShift[WORD_MAX-2:0], miso};
    end else if (wide) begin
      rxNext = {miso, rxShift[WORD_MAX-1:1]};
    end else begin
      rxNext[NARROW-1:0] = {miso, rxShift[NARROW-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (dpStb.load) begin
        txShift <= txWord;
        rxShift <= '0;
      end else begin
        if (dpStb.shiftTx) begin
          txShift <= txLsb ? (txShift >> 1) : (txShift << 1);
        end
        if (dpStb.captureRx) begin
          rxShift <= rxNext;
        end
      end
      if (dpStb.latchRx) begin
        rxHold <= wide ? rxShift : {{(WORD_MAX-NARROW){1'b0}}, rxShift[NARROW-1:0]};
      end
    end
  end

  assign mosi   = txLsb ? txShift[0] : (wide ? txShift[WORD_MAX-1] : txShift[NARROW-1]);
  assign rxWord = rxHold;
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl import spim_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int CS_NUM   = 8,
  parameter int WORD_MAX = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  regAddr_t            regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic                sckTick,
  input  logic [WORD_MAX-1:0] rxWord,
  output dpStrobe_t           dpStb,
  output logic                cfgWide,
  output logic                cfgTxLsb,
  output logic                cfgRxLsb,
  output logic                cfgCpol,
  output logic                busy,
  output logic                causeDone,
  output logic                txWrite,
  output logic                sckOut,
  output logic [CS_NUM-1:0]   csN
);
  localparam int CS_SEL_W = $clog2(CS_NUM);
  localparam int EDGE_W   = $clog2(2 * WORD_MAX);
  localparam int NARROW   = WORD_MAX / 2;
  localparam logic [EDGE_W-1:0] LAST_WIDE   = EDGE_W'(2 * WORD_MAX - 1);
  localparam logic [EDGE_W-1:0] LAST_NARROW = EDGE_W'(2 * NARROW - 1);

  logic                csEn;
  logic [CS_SEL_W-1:0] csSel;
  logic                cfgCpha;
  logic [1:0]          smpDly;
  xferState_t          state;
  logic [EDGE_W-1:0]   edgeCnt;
  logic [2:0]          smpPipe;
  logic                sckQ;

  logic wrCtrl, wrCfg, wrCause, wrTime, start;
  logic edgeNow, sampleNow, shiftNow, capNow, lastEdge, finish, isOdd;
  logic unusedWdata;

  assign unusedWdata = ^regWdata;

  assign wrCtrl  = regWrEn && (regAddr == OFF_CTRL);
  assign wrCfg   = regWrEn && (regAddr == OFF_CFG);
  assign wrCause = regWrEn && (regAddr == OFF_CAUSE);
  assign wrTime  = regWrEn && (regAddr == OFF_TIME);
  assign txWrite = regWrEn && (regAddr == OFF_TX);
  assign start   = txWrite && (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);

  // software-visible fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csEn     <= 1'b0;
      csSel    <= '0;
      cfgWide  <= 1'b0;
      cfgCpol  <= 1'b0;
      cfgCpha  <= 1'b0;
      cfgTxLsb <= 1'b0;
      cfgRxLsb <= 1'b0;
      smpDly   <= 2'd1;
    end else begin
      if (wrCtrl) begin
        csEn  <= regWdata[CTRL_CS_EN];
        csSel <= regWdata[CTRL_SEL_LO +: CS_SEL_W];
      end
      if (wrCfg) begin
        cfgWide  <= regWdata[CFG_WIDE];
        cfgCpol  <= regWdata[CFG_CPOL];
        cfgCpha  <= regWdata[CFG_CPHA];
        cfgTxLsb <= regWdata[CFG_TXLSB];
        cfgRxLsb <= regWdata[CFG_RXLSB];
      end
      if (wrTime) begin
        smpDly <= regWdata[TIM_DLY_LO +: 2];
      end
    end
  end

  // edge classification for the running word
  always_comb begin
    isOdd     = edgeCnt[0];
    lastEdge  = (edgeCnt == (cfgWide ? LAST_WIDE : LAST_NARROW));
    edgeNow   = (state == ST_SHIFT) && sckTick;
    sampleNow = edgeNow && (cfgCpha ? isOdd : !isOdd);
    shiftNow  = edgeNow && (cfgCpha ? (!isOdd && (edgeCnt != '0)) : isOdd);
    unique case (smpDly)
      2'd0:    capNow = sampleNow;
      2'd1:    capNow = smpPipe[0];
      2'd2:    capNow = smpPipe[1];
      default: capNow = smpPipe[2];
    endcase
    finish = (state == ST_DRAIN) && (smpPipe == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      edgeCnt   <= '0;
      smpPipe   <= '0;
      sckQ      <= 1'b0;
      causeDone <= 1'b0;
    end else begin
      smpPipe <= {smpPipe[1:0], sampleNow};
      unique case (state)
        ST_IDLE: begin
          sckQ <= cfgCpol;
          if (start) begin
            state   <= ST_SHIFT;
            edgeCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (sckTick) begin
            sckQ    <= ~sckQ;
            edgeCnt <= edgeCnt + 1'b1;
            if (lastEdge) state <= ST_DRAIN;
          end
        end
        default: begin
          if (smpPipe == '0) state <= ST_IDLE;
        end
      endcase
      if (finish) causeDone <= 1'b1;
      else if (wrCause) causeDone <= 1'b0;
    end
  end

  always_comb begin
    dpStb.load      = start;
    dpStb.shiftTx   = shiftNow;
    dpStb.captureRx = capNow;
    dpStb.latchRx   = finish;
  end

  assign sckOut = sckQ;

  // read mux
  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFF_CTRL: begin
        regRdata[CTRL_CS_EN]               = csEn;
        regRdata[CTRL_SEL_LO +: CS_SEL_W]  = csSel;
        regRdata[CTRL_BUSY]                = busy;
      end
      OFF_CFG: begin
        regRdata[CFG_WIDE]  = cfgWide;
        regRdata[CFG_CPOL]  = cfgCpol;
        regRdata[CFG_CPHA]  = cfgCpha;
        regRdata[CFG_TXLSB] = cfgTxLsb;
        regRdata[CFG_RXLSB] = cfgRxLsb;
      end
      OFF_RX:    regRdata[WORD_MAX-1:0]       = rxWord;
      OFF_CAUSE: regRdata[0]                  = causeDone;
      OFF_TIME:  regRdata[TIM_DLY_LO +: 2]    = smpDly;
      default:   regRdata = '0;
    endcase
  end

  for (genvar g = 0; g < CS_NUM; g++) begin : gCs
    assign csN[g] = !(csEn && (csSel == CS_SEL_W'(g)));
  end
endmodule

// File: rtl/spiMasterCtl.sv
module spiMasterCtl import spim_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int CS_NUM   = 8,
  parameter int WORD_MAX = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [4:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sckTick,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [CS_NUM-1:0] spiCsN
);
  dpStrobe_t           dpStb;
  logic [WORD_MAX-1:0] rxWord;
  logic cfgWide, cfgTxLsb, cfgRxLsb, cfgCpol;
  logic busy, causeDone, txWrite;

  spim_ctrl #(.DATA_W(DATA_W), .CS_NUM(CS_NUM), .WORD_MAX(WORD_MAX)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sckTick(sckTick),
    .rxWord(rxWord), .dpStb(dpStb), .cfgWide(cfgWide), .cfgTxLsb(cfgTxLsb),
    .cfgRxLsb(cfgRxLsb), .cfgCpol(cfgCpol), .busy(busy),
    .causeDone(causeDone), .txWrite(txWrite), .sckOut(spiSck), .csN(spiCsN)
  );

  spim_datapath #(.WORD_MAX(WORD_MAX)) dp_i (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .txWord(regWdata[WORD_MAX-1:0]),
    .wide(cfgWide), .txLsb(cfgTxLsb), .rxLsb(cfgRxLsb), .miso(spiMiso),
    .mosi(spiMosi), .rxWord(rxWord)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int CS_NUM = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sckTick,
  input logic              busy,
  input logic              causeDone,
  input logic              txWrite,
  input logic              cfgCpol,
  input logic              spiSck,
  input logic [CS_NUM-1:0] spiCsN
);
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~spiCsN) <= 1);

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cfgCpol)) |-> (spiSck == cfgCpol));

  a_r3_edge_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !sckTick) |=> $stable(spiSck));

  a_r7_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && txWrite) |=> busy);

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> causeDone);
endmodule

bind spiMasterCtl spim_chk #(.CS_NUM(CS_NUM)) chk_i (
  .clk(clk), .rstN(rstN), .sckTick(sckTick), .busy(busy),
  .causeDone(causeDone), .txWrite(txWrite), .cfgCpol(cfgCpol),
  .spiSck(spiSck), .spiCsN(spiCsN)
);

// File: tb/spiMasterCtl_tb_top.sv
module spiMasterCtl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sckTick = 1'b0;
  logic        spiSck, spiMosi;
  logic        spiMiso = 1'b0;
  logic [7:0]  spiCsN;

  int nChecks = 0;
  int nFails  = 0;
  int sckEdges = 0;

  always #4 clk = ~clk;

  spiMasterCtl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sckTick(sckTick),
    .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  initial forever begin
    @(spiSck);
    sckEdges++;
  end

  // prescaler model: one tick every 5 cycles
  initial forever begin
    repeat (4) @(negedge clk);
    sckTick = 1'b1;
    @(negedge clk);
    sckTick = 1'b0;
  end

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] cfgWord(input bit cpol, input bit cpha, input bit wide,
                                          input bit txLsb, input bit rxLsb);
    return (32'(wide) << 5) | (32'(cpol) << 11) | (32'(cpha) << 12) |
           (32'(txLsb) << 13) | (32'(rxLsb) << 14);
  endfunction

  // slave: sends seq[0] first, records MOSI bits at the sampling edge
  task automatic slaveRun(input bit cpha, input int n, input logic [15:0] seq,
                          input bit corrupt, output logic [15:0] got);
    got = '0;
    if (!cpha) begin
      spiMiso = seq[0];
      for (int i = 0; i < n; i++) begin
        @(spiSck);
        got[i] = spiMosi;
        if (corrupt) begin @(posedge clk); #1 spiMiso = ~spiMiso; end
        @(spiSck);
        if (i < n - 1) spiMiso = seq[i+1];
      end
    end else begin
      for (int i = 0; i < n; i++) begin
        @(spiSck);
        spiMiso = seq[i];
        @(spiSck);
        got[i] = spiMosi;
        if (corrupt) begin @(posedge clk); #1 spiMiso = ~spiMiso; end
      end
    end
  endtask

  task automatic doXfer(input string tag, input bit cpol, input bit cpha, input bit wide,
                        input bit txLsb, input bit rxLsb, input logic [1:0] dly,
                        input logic [15:0] tx, input logic [15:0] slv,
                        input bit corrupt, input bit intrude);
    int n;
    logic [15:0] seq, expRx, expMosi, gotMosi;
    logic [31:0] v;
    bit inv;
    n = wide ? 16 : 8;
    inv = corrupt && (dly >= 2);
    seq = '0; expRx = '0; expMosi = '0;
    for (int i = 0; i < n; i++) begin
      seq[i] = slv[n-1-i];
      expMosi[i] = txLsb ? tx[i] : tx[n-1-i];
      if (rxLsb) expRx[i] = seq[i] ^ inv;
      else       expRx[n-1-i] = seq[i] ^ inv;
    end
    regWrite(5'h04, cfgWord(cpol, cpha, wide, txLsb, rxLsb));
    regWrite(5'h18, 32'(dly) << 6);
    repeat (3) @(negedge clk);
    sckEdges = 0;
    fork
      slaveRun(cpha, n, seq, corrupt, gotMosi);
      begin
        regWrite(5'h08, {16'h0, tx});
        if (intrude) begin
          repeat (6) @(negedge clk);
          regRead(5'h00, v);
          check({tag, " R7 busy bit during transfer"}, {31'h0, v[8]}, 32'h1);
          regWrite(5'h08, {16'h0, ~tx});
        end
      end
    join
    for (int k = 0; k < 40; k++) begin
      regRead(5'h10, v);
      if (v != 0) break;
    end
    check({tag, " R8 cause set"}, v, 32'h1);
    regRead(5'h00, v);
    check({tag, " R7 busy clear"}, {31'h0, v[8]}, 32'h0);
    regRead(5'h0C, v);
    check({tag, " R6/R9 rx word"}, v, {16'h0, expRx});
    check({tag, " R4/R6 mosi bits"}, {16'h0, gotMosi}, {16'h0, expMosi});
    check({tag, " R5 sck transitions"}, sckEdges, 2 * n);
    check({tag, " R3 sck idle"}, {31'h0, spiSck}, {31'h0, cpol});
    regWrite(5'h10, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    regRead(5'h00, v); check("R1 ctrl reset", v, 32'h0);
    regRead(5'h04, v); check("R1 cfg reset", v, 32'h0);
    regRead(5'h10, v); check("R1 cause reset", v, 32'h0);
    regRead(5'h18, v); check("R1 timing reset", v, 32'h40);
    check("R2 cs reset", {24'h0, spiCsN}, 32'hFF);
    check("R3 sck reset", {31'h0, spiSck}, 32'h0);

    // R1 readback
    regWrite(5'h04, 32'h7820); regRead(5'h04, v); check("R1 cfg readback", v, 32'h7820);
    regWrite(5'h18, 32'hC0);   regRead(5'h18, v); check("R1 timing readback", v, 32'hC0);
    regWrite(5'h00, 32'h1D);   regRead(5'h00, v); check("R1 ctrl readback", v, 32'h1D);
    // R3 idle level follows CPOL
    repeat (2) @(negedge clk);
    check("R3 idle high", {31'h0, spiSck}, 32'h1);
    regWrite(5'h04, 32'h0);
    repeat (2) @(negedge clk);
    check("R3 idle low", {31'h0, spiSck}, 32'h0);

    // R2 chip selects
    for (int s = 0; s < 8; s++) begin
      regWrite(5'h00, (32'(s) << 2) | 32'h1);
      @(negedge clk);
      check("R2 cs enabled", {24'h0, spiCsN}, {24'h0, ~(8'h1 << s)});
      regWrite(5'h00, 32'(s) << 2);
      @(negedge clk);
      check("R2 cs disabled", {24'h0, spiCsN}, 32'hFF);
    end
    regWrite(5'h00, 32'h9);

    // directed transfers: modes, order, width
    doXfer("d0", 0, 0, 0, 0, 0, 2'd1, 16'h00A5, 16'h003C, 0, 0);
    doXfer("d1", 1, 1, 1, 0, 0, 2'd1, 16'hC3E1, 16'h5AF0, 0, 0);
    doXfer("d2", 0, 1, 0, 1, 1, 2'd0, 16'h0081, 16'h0013, 0, 0);
    doXfer("d3", 1, 0, 1, 1, 0, 2'd3, 16'h8001, 16'h1234, 0, 0);
    doXfer("d4", 0, 0, 1, 0, 1, 2'd2, 16'hF00D, 16'hBEEF, 0, 0);
    // R9 capture delay against a slave that flips one cycle after the edge
    doXfer("r9a", 0, 0, 0, 0, 0, 2'd1, 16'h005A, 16'h00C6, 1, 0);
    doXfer("r9b", 0, 0, 0, 0, 0, 2'd2, 16'h005A, 16'h00C6, 1, 0);
    doXfer("r9c", 1, 1, 1, 0, 0, 2'd0, 16'h1357, 16'h9BDF, 1, 0);
    doXfer("r9d", 1, 1, 1, 0, 0, 2'd3, 16'h1357, 16'h9BDF, 1, 0);
    // R7 transmit write during a transfer is ignored
    doXfer("r7", 0, 0, 0, 0, 0, 2'd1, 16'h0096, 16'h0069, 0, 1);

    // R8 flag holds until written
    doXfer("r8", 0, 1, 0, 0, 0, 2'd1, 16'h0077, 16'h00E4, 0, 0);
    regWrite(5'h08, 32'h0011);
    repeat (120) @(negedge clk);
    regRead(5'h10, v); check("R8 cause sticky", v, 32'h1);
    regRead(5'h10, v); check("R8 cause sticky after read", v, 32'h1);
    regWrite(5'h10, 32'h0);
    regRead(5'h10, v); check("R8 cause cleared", v, 32'h0);

    // random mix
    for (int r = 0; r < 20; r++) begin
      logic [31:0] a, b, m;
      a = $urandom; b = $urandom; m = $urandom;
      doXfer("rnd", m[0], m[1], m[2], m[3], m[4], m[6:5], a[15:0],
             m[2] ? b[15:0] : {8'h0, b[7:0]}, 0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule